// File: doc/BRIEF.md
# Memory-Bus Event Interrupt and Wait-Pin Input Unit

This block gathers the interrupt events of an external memory bus controller into one interrupt line. There are two kinds of source. The first is a pair of single-cycle event pulses from the internal flash engine: a FIFO-threshold event and a transfer-count-reached event. The second is one edge-triggered source for each asynchronous wait pin. Each wait pin passes through a two-flop synchronizer. A per-pin edge detector then watches for either a rising or a falling edge, whichever that pin is set to.

Software sees the block through a small register port. Every source has a sticky status bit that is cleared by writing 1, and an enable bit. The interrupt output is the registered OR of the enabled status bits. The same wait pins can also be read as general-purpose inputs, and a direction readback always reports them as inputs. The source numbering is fixed: source 0 is the FIFO-threshold event, source 1 is the count-reached event, and source 2+i belongs to wait pin i. The number of wait pins is a parameter, 2 by default.

Top module: `mbus_evt_irq`

## Requirements
- R1: A one-cycle pulse on `evt_fifo` sets status bit 0 at the clock edge where it is sampled.
- R2: A one-cycle pulse on `evt_tc` sets status bit 1 at the clock edge where it is sampled.
- R3: A selected edge on `wait_pin[i]` sets status bit 2+i. Because of the two-flop synchronizer, the bit becomes visible after the third rising clock edge that follows the pin change.
- R4: The edge-select register (offset 2, bit i for pin i) picks the edge for each pin: 1 selects rising and 0 selects falling. An edge of the other direction leaves the status bit clear. The reset value is 0.
- R5: Status (offset 0) bits are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A set arriving in the same cycle as a clear wins.
- R6: The enable register (offset 1, bit n for source n) is read/write and resets to 0.
- R7: `irq` is high exactly one clock after a cycle in which some status bit and its enable bit are both 1.
- R8: Offset 3 reads the synchronized wait-pin levels, with bit i holding pin i.
- R9: Offset 4 (direction) always reads 0, meaning every pin is an input. Writes to offsets 3 and 4 have no effect.
- R10: After reset, every register reads 0 and `irq` is low. Unused offsets and unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_fifo | input | 1 | Flash-engine FIFO-threshold event pulse (source 0) |
| evt_tc | input | 1 | Flash-engine count-reached event pulse (source 1) |
| wait_pin | input | N_WAIT | Asynchronous wait pins (sources 2 and up) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that `evt_fifo`, `evt_tc` and the register port are synchronous to `clk`. They make no assumption about how long a wait-pin level is held. The bench drives every input away from the rising edge, including the wait pins, so the two-flop synchronizer always captures a clean value. A behavioural model that runs cycle by cycle can therefore predict the exact edge on which each level arrives. Directed sequences cover set-versus-clear collisions, edges of the wrong polarity and writes to read-only offsets. After that, a long pseudo-random stream toggles pins and issues writes at arbitrary offsets, and the model is compared on every clock.

// File: rtl/mbus_evt_pkg.sv
package mbus_evt_pkg;
   // register word offsets
   localparam int unsigned OFS_STATUS  = 0;
   localparam int unsigned OFS_ENABLE  = 1;
   localparam int unsigned OFS_EDGESEL = 2;
   localparam int unsigned OFS_LEVEL   = 3;
   localparam int unsigned OFS_DIR     = 4;
   // engine event sources precede wait-pin sources
   localparam int unsigned NUM_ENGINE_EVT = 2;
   localparam int unsigned SRC_FIFO       = 0;
   localparam int unsigned SRC_TC         = 1;
endpackage

// File: rtl/mbus_evt_sync.sv
module mbus_evt_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mbus_evt_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbus_evt_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/mbus_evt_edge.sv
module mbus_evt_edge #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_sel,
   output logic [WIDTH-1:0] edge_hit
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic went_up, went_down;
      assign went_up     = level[i] & ~prev_q[i];
      assign went_down   = ~level[i] & prev_q[i];
      assign edge_hit[i] = rise_sel[i] ? went_up : went_down;
   end

   // an edge report always corresponds to a level change
   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit != '0) |-> (level != prev_q)); // R4
endmodule

// File: rtl/mbus_evt_stat.sv
module mbus_evt_stat #(
   parameter int unsigned NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_in,
   input  logic [NSRC-1:0] clr_in,
   input  logic [NSRC-1:0] enable,
   output logic [NSRC-1:0] status,
   output logic            irq
);
   logic [NSRC-1:0] st_q;
   logic            irq_q;
   logic            pending;

   assign pending = |(st_q & enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= (st_q & ~clr_in) | set_in;
         irq_q <= pending;
      end
   end

   assign status = st_q;
   assign irq    = irq_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_chk
      AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[i] && !clr_in[i]) |=> st_q[i]); // R5
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_in[i] |=> st_q[i]); // R5
   end

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & enable)) |=> irq); // R7
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & enable)) |=> !irq); // R7
endmodule

// File: rtl/mbus_evt_irq.sv
module mbus_evt_irq
   import mbus_evt_pkg::*;
#(
   parameter int unsigned N_WAIT      = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_fifo,
   input  logic              evt_tc,
   input  logic [N_WAIT-1:0] wait_pin,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned NSRC = NUM_ENGINE_EVT + N_WAIT;

   if (N_WAIT < 1) begin : g_bad_nwait
      $error("mbus_evt_irq: N_WAIT must be at least 1");
   end
   if (NSRC >= DATA_W) begin : g_bad_dataw
      $error("mbus_evt_irq: DATA_W must exceed the source count");
   end
   if (ADDR_W < 3) begin : g_bad_addrw
      $error("mbus_evt_irq: ADDR_W must be at least 3");
   end

   logic [NSRC-1:0]   en_q;
   logic [N_WAIT-1:0] rise_q;
   logic [N_WAIT-1:0] pin_lvl;
   logic [N_WAIT-1:0] pin_edge;
   logic [NSRC-1:0]   set_vec;
   logic [NSRC-1:0]   clr_vec;
   logic [NSRC-1:0]   status;
   logic              wr_status, wr_enable, wr_edgesel;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:NSRC];

   assign wr_status  = reg_we && (reg_addr == ADDR_W'(OFS_STATUS));
   assign wr_enable  = reg_we && (reg_addr == ADDR_W'(OFS_ENABLE));
   assign wr_edgesel = reg_we && (reg_addr == ADDR_W'(OFS_EDGESEL));

   mbus_evt_sync #(.WIDTH(N_WAIT), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (wait_pin),
      .sync_out (pin_lvl)
   );

   mbus_evt_edge #(.WIDTH(N_WAIT)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (pin_lvl),
      .rise_sel (rise_q),
      .edge_hit (pin_edge)
   );

   assign set_vec[SRC_FIFO]            = evt_fifo;
   assign set_vec[SRC_TC]              = evt_tc;
   assign set_vec[NSRC-1:NUM_ENGINE_EVT] = pin_edge;
   assign clr_vec = wr_status ? reg_wdata[NSRC-1:0] : '0;

   mbus_evt_stat #(.NSRC(NSRC)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_in (set_vec),
      .clr_in (clr_vec),
      .enable (en_q),
      .status (status),
      .irq    (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         rise_q <= '0;
      end else begin
         if (wr_enable)  en_q   <= reg_wdata[NSRC-1:0];
         if (wr_edgesel) rise_q <= reg_wdata[N_WAIT-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_STATUS):  reg_rdata[NSRC-1:0]   = status;
         ADDR_W'(OFS_ENABLE):  reg_rdata[NSRC-1:0]   = en_q;
         ADDR_W'(OFS_EDGESEL): reg_rdata[N_WAIT-1:0] = rise_q;
         ADDR_W'(OFS_LEVEL):   reg_rdata[N_WAIT-1:0] = pin_lvl;
         default:              reg_rdata = '0; // direction and unused: all inputs
      endcase
   end

   AST_FIFO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fifo |=> status[SRC_FIFO]); // R1
   AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tc |=> status[SRC_TC]); // R2
   AST_DIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_DIR)) |-> (reg_rdata == '0)); // R9
   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enable |=> $stable(en_q)); // R6
endmodule

// File: tb/sim_mbus_evt_irq.sv
`timescale 1ns/1ps
module sim_mbus_evt_irq;
   localparam int NW   = 2;
   localparam int NS   = NW + 2;
   localparam int DW   = 32;
   localparam int AW   = 3;
   localparam time TCK = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_fifo = 1'b0, evt_tc = 1'b0;
   logic [NW-1:0] wait_pin = '0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(TCK/2) clk = ~clk;

   mbus_evt_irq #(.N_WAIT(NW), .DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_fifo(evt_fifo), .evt_tc(evt_tc),
      .wait_pin(wait_pin), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   // behavioural reference model
   logic [NS-1:0] m_st, m_en;
   logic [NW-1:0] m_rise, m_s1, m_s2, m_prev;
   logic          m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = '0; m_en = '0; m_rise = '0; m_s1 = '0; m_s2 = '0;
         m_prev = '0; m_irq = 1'b0;
      end else begin
         logic [NW-1:0] edg;
         logic [NS-1:0] clr;
         edg   = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & ~m_rise);
         clr   = (reg_we && reg_addr == 0) ? reg_wdata[NS-1:0] : '0;
         m_irq = |(m_st & m_en);
         m_st  = (m_st & ~clr) | {edg, evt_tc, evt_fifo};
         if (reg_we && reg_addr == 1) m_en   = reg_wdata[NS-1:0];
         if (reg_we && reg_addr == 2) m_rise = reg_wdata[NW-1:0];
         m_prev = m_s2; m_s2 = m_s1; m_s1 = wait_pin;
      end
   end

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
      logic [DW-1:0] r;
      r = '0;
      case (a)
         0: r[NS-1:0] = m_st;
         1: r[NS-1:0] = m_en;
         2: r[NW-1:0] = m_rise;
         3: r[NW-1:0] = m_s2;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #3;
      if (rst_n && !done) begin
         string rq;
         case (reg_addr)
            0: rq = "R5 status";
            1: rq = "R6 enable";
            2: rq = "R4 edge-select";
            3: rq = "R8 level";
            4: rq = "R9 direction";
            default: rq = "R10 unused";
         endcase
         chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
         chk(rq, reg_rdata, model_rd(reg_addr));
      end
   end

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      tick(1);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, input string req, input logic [DW-1:0] exp);
      reg_addr = AW'(a);
      #1;
      chk(req, reg_rdata, exp);
   endtask

   initial begin
      logic [31:0] lf;
      tick(2);
      rst_n = 1'b1;
      tick(2);
      rd(0, "R10 status after reset", 0);
      rd(1, "R10 enable after reset", 0);
      rd(2, "R10 edge-select after reset", 0);
      chk("R10 irq after reset", {31'b0, irq}, 0);

      wr(1, 32'hF);
      rd(1, "R6 enable readback", 32'hF);

      evt_fifo = 1'b1; tick(1); evt_fifo = 1'b0;
      rd(0, "R1 fifo event sets bit 0", 32'h1);
      tick(1);
      chk("R7 irq one cycle after status", {31'b0, irq}, 1);

      wr(0, 32'h1);
      rd(0, "R5 write-1 clears", 0);
      tick(1);
      chk("R7 irq drops", {31'b0, irq}, 0);

      evt_tc = 1'b1; tick(1); evt_tc = 1'b0;
      rd(0, "R2 count event sets bit 1", 32'h2);
      wr(0, 32'h0);
      rd(0, "R5 write-0 keeps", 32'h2);
      evt_tc = 1'b1; wr(0, 32'h2); evt_tc = 1'b0;
      rd(0, "R5 set beats clear", 32'h2);
      wr(0, 32'h2);
      rd(0, "R5 cleared", 0);

      wait_pin = 2'b01; tick(5);
      rd(0, "R4 rising ignored when falling selected", 0);
      rd(3, "R8 pin0 level", 32'h1);
      wait_pin = 2'b00; tick(2);
      rd(0, "R3 not yet after two edges", 0);
      tick(1);
      rd(0, "R3 pin0 falling sets bit 2", 32'h4);
      wr(0, 32'h4);

      wr(2, 32'h2);
      rd(2, "R4 edge-select readback", 32'h2);
      wait_pin = 2'b10; tick(3);
      rd(0, "R3 pin1 rising sets bit 3", 32'h8);
      wr(0, 32'hF);

      wr(1, 32'h0);
      evt_fifo = 1'b1; tick(1); evt_fifo = 1'b0; tick(3);
      chk("R7 masked source keeps irq low", {31'b0, irq}, 0);
      wr(0, 32'hF);

      wr(3, 32'hFF); wr(4, 32'hFF);
      rd(3, "R9 level write ignored", 32'h2);
      rd(4, "R9 direction reads inputs", 0);
      rd(7, "R10 unused offset", 0);

      lf = 32'h1ACE_B00C;
      for (int c = 0; c < 4000; c++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         wait_pin  = lf[1:0];
         evt_fifo  = (lf[6:4] == 0);
         evt_tc    = (lf[9:7] == 0);
         reg_addr  = lf[12:10] % 6;
         reg_we    = (lf[15:13] == 0);
         reg_wdata = {28'b0, lf[19:16]};
         tick(1);
      end
      reg_we = 1'b0; evt_fifo = 1'b0; evt_tc = 1'b0;
      tick(2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(TCK * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule